// File: doc/BRIEF.md
# Double-Sampling Timing-Error Register

This block is a pipeline register bank that takes two samples of every data bit. The main register captures `d` on the rising edge of `clk`. A shadow register captures the same `d` again on the rising edge of `clk_del`, a copy of `clk` shifted later within the cycle. The shadow copy is taken as the correct value because its setup window is wider. When any bit of the two samples disagrees, the stage flags a timing error. If repair is enabled, it loads the shadow copy into the main register on the next `clk` edge, so the late-arriving value reaches `q` and the pipeline keeps moving.

The per-bit disagreements are OR-reduced into one stage-level flag. That flag passes through a chain of `SYNC_STAGES` flops on `clk`, which keeps a marginal comparison from reaching the outside as a metastable level. It leaves the block active-low as `error_n`. During the cycle in which the main register holds a repaired value, it did not take `d`, so the comparison is masked for that cycle. Upstream logic replays the value that was present at the repair edge. Correct operation assumes that the fastest path into `d` is slower than the clock skew plus hold time. If it is not, the next word reaches the shadow sample.

Top module: `dsr_bank`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros and `error_n` is 1.
- R2: When `d` does not change between a `clk` rising edge and the following `clk_del` rising edge, `q` shows the value `d` had at that `clk` edge, and `error_n` stays 1.
- R3: A change of `d` inside the `clk`-to-`clk_del` window that alters any single bit position, or any set of positions, of the captured word is detected as a mismatch.
- R4: With `fix_en` = 1, the `clk` edge after a mismatched capture loads the late (shadow) sample into `q`, and the value on `d` at that edge is dropped. The edge after that captures `d` again.
- R5: A mismatched capture at `clk` edge t0 drives `error_n` low from edge t0+`SYNC_STAGES` to edge t0+`SYNC_STAGES`+1, which is exactly one clock cycle. The level is 0 for error and 1 for no error.
- R6: With `fix_en` = 0, no reload happens and `q` takes `d` at every edge, but the mismatch is still reported on `error_n` as in R5.
- R7: During the cycle in which `q` holds a repaired value, the comparison is suppressed. A later `d` that differs from the repaired word produces no second error pulse.
- R8: A change of `d` inside the window to a value equal to the one already captured produces no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main capture clock |
| clk_del | input | 1 | Delayed copy of clk used for the shadow sample |
| rst_n | input | 1 | Asynchronous reset, active low |
| fix_en | input | 1 | 1: reload the main register from the shadow copy when a mismatch is detected |
| d | input | WIDTH | Data from the logic stage |
| q | output | WIDTH | Registered stage output |
| error_n | output | 1 | Synchronized stage timing-error flag, active low |

## Verification
A sweep over every 8-bit word with `d` held stable across the sampling window separates a correct capture path from one that falsely flags errors. Late single-bit flips at each bit position show that every comparator feeds the OR-reduction. Multi-bit and equal-value late changes separate a true disagreement check from one that only watches for activity on `d`. Each late-change case is run with repair on and off, with a third value on `d` at the repair edge. This shows whether `q` took the shadow copy or the new data, whether the pulse falls on the right edge and lasts one cycle, and whether the masked repair cycle suppresses a second pulse.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    // Source selected by the main register's input multiplexer.
    typedef enum logic {
        SRC_DATA   = 1'b0,
        SRC_SHADOW = 1'b1
    } cap_src_e;

endpackage

// File: rtl/dsr_shadow.sv
module dsr_shadow #(
    parameter int WIDTH = 8
) (
    input  logic             clk_del,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] shadow_o
);

    logic [WIDTH-1:0] shadow_d;
    logic [WIDTH-1:0] shadow_q;

    // Second sample of the stage data, taken on the late clock.
    always_comb begin
        shadow_d = d;
    end

    always_ff @(posedge clk_del or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else begin
            shadow_q <= shadow_d;
        end
    end

    assign shadow_o = shadow_q;

endmodule

// File: rtl/dsr_cmp.sv
module dsr_cmp #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] early_i,
    input  logic [WIDTH-1:0] late_i,
    input  logic             arm_i,
    output logic [WIDTH-1:0] bit_mis_o,
    output logic             any_mis_o
);

    logic [WIDTH-1:0] diff;

    // One comparator per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign diff[i] = early_i[i] ^ late_i[i];
    end

    always_comb begin
        bit_mis_o = diff & {WIDTH{arm_i}};
        any_mis_o = |bit_mis_o;
    end

endmodule

// File: rtl/dsr_sync.sv
module dsr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    output logic first_o,
    output logic last_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d[0] = flag_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign first_o = chain_q[0];
    assign last_o  = chain_q[LAST];

endmodule

// File: rtl/dsr_bank.sv
module dsr_bank #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             clk_del,
    input  logic             rst_n,
    input  logic             fix_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             error_n
);
    import dsr_pkg::*;

    // Main register state: the data word and whether it came from d.
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             armed;
    } main_st_t;

    main_st_t         st_d;
    main_st_t         st_q;
    logic [WIDTH-1:0] shadow_q;
    logic [WIDTH-1:0] bit_mis;
    logic             mis_any;
    logic             restore;
    logic             err_first;
    logic             err_last;
    cap_src_e         src;

    dsr_shadow #(.WIDTH(WIDTH)) shadow_i (
        .clk_del  (clk_del),
        .rst_n    (rst_n),
        .d        (d),
        .shadow_o (shadow_q)
    );

    // Compare only when the main word was taken from d.
    dsr_cmp #(.WIDTH(WIDTH)) cmp_i (
        .early_i   (st_q.data),
        .late_i    (shadow_q),
        .arm_i     (st_q.armed),
        .bit_mis_o (bit_mis),
        .any_mis_o (mis_any)
    );

    dsr_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_i  (mis_any),
        .first_o (err_first),
        .last_o  (err_last)
    );

    always_comb begin
        restore = mis_any & fix_en;
        src     = restore ? SRC_SHADOW : SRC_DATA;
        st_d    = st_q;
        if (src == SRC_SHADOW) begin
            st_d.data  = shadow_q;
            st_d.armed = 1'b0;
        end else begin
            st_d.data  = d;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q       = st_q.data;
    assign error_n = ~err_last;

endmodule

// File: rtl/dsr_bank_chk.sv
module dsr_bank_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fix_en,
    input logic [WIDTH-1:0] d,
    input logic [WIDTH-1:0] q,
    input logic [WIDTH-1:0] shadow_q,
    input logic             mis_any,
    input logic             restore,
    input logic             err_first
);

    assert_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (q == $past(shadow_q)));

    assert_nofix_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fix_en |=> (q == $past(d)));

    assert_detect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mis_any |=> err_first);

    assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> !mis_any);

    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_first && $past(restore)) |=> !err_first);

endmodule

bind dsr_bank dsr_bank_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fix_en    (fix_en),
    .d         (d),
    .q         (q),
    .shadow_q  (shadow_q),
    .mis_any   (mis_any),
    .restore   (restore),
    .err_first (err_first)
);

// File: tb/dsr_bank_tb.sv
module dsr_bank_tb_top;

    localparam int W = 8;

    logic         clk;
    logic         clk_del;
    logic         rst_n;
    logic         fix_en;
    logic [W-1:0] d;
    logic [W-1:0] q;
    logic         error_n;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    dsr_bank #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
        .clk     (clk),
        .clk_del (clk_del),
        .rst_n   (rst_n),
        .fix_en  (fix_en),
        .d       (d),
        .q       (q),
        .error_n (error_n)
    );

    initial begin
        clk = 0;
        forever #10 clk = ~clk;
    end

    initial begin
        clk_del = 0;
        #6;
        forever #10 clk_del = ~clk_del;
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Clean capture: d set after clk_del, captured at next edge.
    task automatic clean(input logic [W-1:0] v);
        @(posedge clk);
        #10 d = v;
        @(posedge clk);
        #5;
        chk("R2 q", q, v);
        chk("R2 error_n", {7'd0, error_n}, 8'd1);
    endtask

    // Late change a->b inside the window, c presented at the repair edge.
    task automatic late(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] c, input logic fx, input string req);
        logic [W-1:0] exp_q1;
        logic         mism;
        mism   = (a != b);
        exp_q1 = (fx && mism) ? b : c;
        @(posedge clk);
        #10 d = a; fix_en = fx;
        @(posedge clk);          // t0
        #2 d = b;
        #8 d = c;
        #5;
        chk({req, " q after t0"}, q, a);
        @(posedge clk);          // t1
        #15;
        chk({req, " R4/R6 q after t1"}, q, exp_q1);
        chk({req, " R5 no early pulse"}, {7'd0, error_n}, 8'd1);
        @(posedge clk);          // t2
        #15;
        chk({req, " R5/R8 error_n at t2"}, {7'd0, error_n}, mism ? 8'd0 : 8'd1);
        chk({req, " R4 q after t2"}, q, c);
        @(posedge clk);          // t3
        #15;
        chk({req, " R5/R7 one cycle pulse"}, {7'd0, error_n}, 8'd1);
        @(posedge clk);
        #15;
        chk({req, " R7 no second pulse"}, {7'd0, error_n}, 8'd1);
    endtask

    initial begin
        rst_n  = 0;
        fix_en = 1;
        d      = '0;
        repeat (3) @(posedge clk);
        #5;
        chk("R1 q in reset", q, '0);
        chk("R1 error_n in reset", {7'd0, error_n}, 8'd1);
        d = 8'h5A;
        @(posedge clk);
        #5;
        chk("R1 q held in reset", q, '0);
        @(posedge clk);
        #10 rst_n = 1;

        // R2: every word with stable data across the window.
        for (int v = 0; v < 256; v++) clean(v[W-1:0]);

        // R3: each bit position, both repair modes.
        for (int i = 0; i < W; i++) begin
            late(8'hA5, 8'hA5 ^ (8'd1 << i), 8'h3C, 1'b1, "R3 bit fix");
            late(8'h0F, 8'h0F ^ (8'd1 << i), 8'hC3, 1'b0, "R3 bit nofix");
        end
        // R3: multi-bit disagreements.
        late(8'h00, 8'hFF, 8'h81, 1'b1, "R3 all bits R4");
        late(8'h12, 8'h34, 8'h56, 1'b0, "R3 multi R6");
        late(8'hF0, 8'h0F, 8'hF0, 1'b1, "R7 c equals a");
        // R8: late activity to the same value.
        late(8'h77, 8'h77, 8'h99, 1'b1, "R8 same fix");
        late(8'h3E, 8'h3E, 8'h41, 1'b0, "R8 same nofix");

        clean(8'hC7);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule